// File: doc/BRIEF.md
# UART Transceiver with Idle-Line Detection

This block is a full-duplex asynchronous serial transceiver. Both directions are timed by a single-cycle tick that arrives sixteen times per bit period. A single control input selects a data word of 8 or 9 bits, and this setting applies to both directions. Each direction pairs a holding register with its own shift register. On the transmit side a write loads the holding register. The word then moves to the shift register and leaves on the line LSB first, framed by one low start bit and one high stop bit.

The receiver brings the line into the clock domain and finds a start edge. It takes three samples in the middle of every bit and keeps the majority value. When a word completes, it moves into the receive data register. The receiver raises flags for noise, framing error and overrun. After at least one frame has been received, it also flags an idle line once it sees a whole frame time of continuous ones. A one-cycle read strobe returns the received word and clears the receive flags.

Top module: `uart_xcvr`

## Requirements
- R1: With `word9`=0 a frame carries 8 data bits, and with `word9`=1 it carries 9. Data is sent and received LSB first, and in 8-bit mode bit 8 of `rd_data` reads 0.
- R2: The transmitter holds `tx_out` high when it has nothing to send. It drives the line low for 16 ticks as the start bit and high for 16 ticks as the stop bit.
- R3: `txe` reads 1 when the holding register is empty. It rises again once a written word has moved into the shift register. A write made while `txe`=0 is ignored, and the held word stays unchanged.
- R4: `tc` rises when the stop bit ends and the holding register is empty. A write that is accepted clears it. `tc` reads 0 during a back-to-back transfer.
- R5: When a frame completes and `rxne`=0, the word appears on `rd_data` and `rxne` goes to 1.
- R6: A `rd_en` pulse clears `rxne`, `ore`, `ne`, `fe` and `idle`.
- R7: When a frame completes while `rxne`=1, `ore` goes to 1. The new word is dropped and `rd_data` keeps the old one.
- R8: Each bit is sampled at ticks 7, 8 and 9 of its 16 ticks, with tick 0 being the tick that detected the start edge. The majority value is kept. If the three samples of any bit in the frame disagree, `ne` is set together with the word.
- R9: A stop bit whose majority value is low sets `fe`, and the word is still delivered.
- R10: A low pulse on the line that has ended by ticks 7 to 9 is discarded as a false start. No word is delivered, and the next valid frame is received correctly.
- R11: `idle` is set when the line stays high for one frame time after a received frame (160 ticks with 8-bit words, 176 ticks with 9-bit words). It is never set before the first frame. After it is set, it is not set again until a further frame has been received.
- R12: After reset `tx_out`=1, `txe`=1 and `tc`=1, and `rxne`, `ore`, `ne`, `fe` and `idle` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the baud rate |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 9 | Word to transmit |
| rd_en | input | 1 | Read strobe for the receive data register |
| rd_data | output | 9 | Received word |
| rx_in | input | 1 | Serial receive line |
| tx_out | output | 1 | Serial transmit line |
| txe | output | 1 | Transmit holding register empty |
| tc | output | 1 | Transmission complete |
| rxne | output | 1 | Receive data register holds an unread word |
| idle | output | 1 | Idle line detected |
| ore | output | 1 | Overrun |
| ne | output | 1 | Noise seen in the last delivered word |
| fe | output | 1 | Framing error in the last delivered word |

## Verification
The assertions assume three things about the inputs. First, `tick16` is a single-cycle pulse with at least three clocks between pulses, so that the two-stage line synchronizer settles between ticks. Second, `word9` changes only while both directions are idle. Third, `wr_en` and `rd_en` are single-cycle strobes. The stimulus raises the tick on every fourth clock and changes `rx_in` only on the clock right after a tick. This places each glitch on exactly one of the three mid-bit samples. The word length is changed only between frames, once both directions are idle.

// File: rtl/uart_xcvr_pkg.sv
// Shared types and helpers for the UART transceiver.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package uart_xcvr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } line_state_t;

    // Majority of three samples.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_xcvr_tx.sv
// Transmit path: one-word holding register feeding a shift register that
// frames each word with a low start bit and a high stop bit, LSB first.
// Assumes tick is a single-cycle pulse at OSR times the baud rate and that
// word9 is stable while a frame is on the line.
module uart_xcvr_tx
    import uart_xcvr_pkg::*;
#(
    parameter int OSR = 16,
    parameter int W   = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         word9,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         tx_out,
    output logic         txe,
    output logic         tc
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(W);

    logic          hold_v;
    logic [W-1:0]  hold_d;
    logic [W-1:0]  sh;
    line_state_t   st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] idx;
    logic [BW-1:0] last_idx;
    logic          wr_ok;
    logic          load;
    logic          bit_end;

    assign last_idx = word9 ? BW'(W - 1) : BW'(W - 2);
    assign wr_ok    = wr_en && !hold_v;
    assign load     = (st == ST_IDLE) && hold_v;
    assign bit_end  = tick && (cnt == CW'(OSR - 1));
    assign txe      = !hold_v;

    // Holding register: accept a write only when empty, release on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_d <= '0;
        end else if (wr_ok) begin
            hold_v <= 1'b1;
            hold_d <= wr_data;
        end else if (load) begin
            hold_v <= 1'b0;
        end
    end

    // Shift register and frame sequencer driving the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            idx    <= '0;
            sh     <= '0;
            tx_out <= 1'b1;
        end else begin
            if (st != ST_IDLE && tick) begin
                cnt <= bit_end ? '0 : cnt + 1'b1;
            end
            case (st)
                ST_IDLE: begin
                    if (load) begin
                        st     <= ST_START;
                        tx_out <= 1'b0;
                        sh     <= hold_d;
                        cnt    <= '0;
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        st     <= ST_DATA;
                        tx_out <= sh[0];
                        idx    <= '0;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        if (idx == last_idx) begin
                            st     <= ST_STOP;
                            tx_out <= 1'b1;
                        end else begin
                            idx    <= idx + 1'b1;
                            sh     <= sh >> 1;
                            tx_out <= sh[1];
                        end
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Transmission-complete flag: set at stop end with nothing pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= 1'b1;
        end else if (wr_ok) begin
            tc <= 1'b0;
        end else if (st == ST_STOP && bit_end && !hold_v) begin
            tc <= 1'b1;
        end
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START) |-> !tx_out);                           // R2
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP) |-> tx_out);                             // R2
    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !txe) |=> $stable(hold_d));                    // R3
    AST_TC_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> txe);                                             // R4

endmodule

// File: rtl/uart_xcvr_rx.sv
// Receive path: two-stage line synchronizer, start-edge search, three-sample
// majority vote at mid-bit, and idle-line timer armed by each received frame.
// Assumes tick pulses are at least three clocks apart so the synchronized
// line has settled before each sample, and word9 is stable during a frame.
module uart_xcvr_rx
    import uart_xcvr_pkg::*;
#(
    parameter int OSR = 16,
    parameter int W   = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         word9,
    input  logic         rx_in,
    output logic         done,
    output logic [W-1:0] word,
    output logic         noise,
    output logic         ferr,
    output logic         idle_evt
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(W);
    localparam int MID = OSR / 2;
    localparam int FW  = $clog2(OSR * (W + 2) + 1);

    logic          s1, rx_s;
    line_state_t   st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] idx;
    logic [BW-1:0] last_idx;
    logic [W-1:0]  sh;
    logic          smp_a, smp_b;
    logic          nacc;
    logic          armed;
    logic [FW-1:0] icnt;
    logic [FW-1:0] frame_m1;
    logic          bit_end, at_vote, vote, split;

    assign last_idx = word9 ? BW'(W - 1) : BW'(W - 2);
    assign frame_m1 = word9 ? FW'(OSR * (W + 2) - 1) : FW'(OSR * (W + 1) - 1);
    assign bit_end  = tick && (cnt == CW'(OSR - 1));
    assign at_vote  = tick && (cnt == CW'(MID + 1));
    assign vote     = maj3(smp_a, smp_b, rx_s);
    assign split    = !((smp_a == smp_b) && (smp_b == rx_s));

    // Line synchronizer, idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            s1   <= rx_in;
            rx_s <= s1;
        end
    end

    // Frame sequencer, sampling, word assembly and idle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            sh       <= '0;
            smp_a    <= 1'b1;
            smp_b    <= 1'b1;
            nacc     <= 1'b0;
            armed    <= 1'b0;
            icnt     <= '0;
            done     <= 1'b0;
            word     <= '0;
            noise    <= 1'b0;
            ferr     <= 1'b0;
            idle_evt <= 1'b0;
        end else begin
            done     <= 1'b0;
            idle_evt <= 1'b0;
            if (st != ST_IDLE && tick) begin
                cnt <= bit_end ? '0 : cnt + 1'b1;
                if (cnt == CW'(MID - 1)) smp_a <= rx_s;
                if (cnt == CW'(MID))     smp_b <= rx_s;
            end
            case (st)
                ST_IDLE: begin
                    if (tick) begin
                        if (!rx_s) begin
                            st   <= ST_START;
                            cnt  <= CW'(1);
                            sh   <= '0;
                            nacc <= 1'b0;
                            icnt <= '0;
                        end else if (armed) begin
                            if (icnt == frame_m1) begin
                                idle_evt <= 1'b1;
                                armed    <= 1'b0;
                                icnt     <= '0;
                            end else begin
                                icnt <= icnt + 1'b1;
                            end
                        end
                    end
                end
                ST_START: begin
                    if (at_vote) begin
                        if (vote) st <= ST_IDLE;
                        else      nacc <= split;
                    end else if (bit_end) begin
                        st  <= ST_DATA;
                        idx <= '0;
                    end
                end
                ST_DATA: begin
                    if (at_vote) begin
                        sh[idx] <= vote;
                        nacc    <= nacc | split;
                    end else if (bit_end) begin
                        if (idx == last_idx) st <= ST_STOP;
                        else                 idx <= idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_vote) begin
                        done  <= 1'b1;
                        word  <= sh;
                        noise <= nacc | split;
                        ferr  <= !vote;
                        armed <= 1'b1;
                        icnt  <= '0;
                        st    <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                         // R5
    AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START && at_vote && vote) |=> (st == ST_IDLE && !done)); // R10
    AST_IDLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |=> !idle_evt);                                 // R11

endmodule

// File: rtl/uart_xcvr_rxflags.sv
// Receive data register and receive status flags.
// Assumes done and idle_evt are single-cycle pulses and rd_en is a strobe.
module uart_xcvr_rxflags #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done,
    input  logic [W-1:0] word,
    input  logic         noise,
    input  logic         ferr,
    input  logic         idle_evt,
    input  logic         rd_en,
    output logic [W-1:0] rx_data,
    output logic         rxne,
    output logic         ore,
    output logic         ne,
    output logic         fe,
    output logic         idle
);
    logic accept;

    assign accept = done && (!rxne || rd_en);

    // Data register and flags: read clears, new word loads, busy word overruns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rxne    <= 1'b0;
            ore     <= 1'b0;
            ne      <= 1'b0;
            fe      <= 1'b0;
            idle    <= 1'b0;
        end else begin
            if (rd_en) begin
                rxne <= 1'b0;
                ore  <= 1'b0;
                ne   <= 1'b0;
                fe   <= 1'b0;
                idle <= 1'b0;
            end
            if (accept) begin
                rx_data <= word;
                rxne    <= 1'b1;
                ne      <= noise;
                fe      <= ferr;
            end
            if (done && rxne && !rd_en) ore <= 1'b1;
            if (idle_evt) idle <= 1'b1;
        end
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !done) |=> !rxne);                             // R6
    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rxne && !rd_en) |=> $stable(rx_data));                  // R7
    AST_OVERRUN_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ore |-> rxne);                                           // R7

endmodule

// File: rtl/uart_xcvr.sv
// Top of the UART transceiver: joins the transmit path, the receive path
// and the receive flag register. Assumes a single clock domain, with tick16
// a one-cycle pulse at sixteen times the baud rate.
module uart_xcvr #(
    parameter int OSR = 16,
    parameter int W   = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick16,
    input  logic         word9,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    input  logic         rx_in,
    output logic         tx_out,
    output logic         txe,
    output logic         tc,
    output logic         rxne,
    output logic         idle,
    output logic         ore,
    output logic         ne,
    output logic         fe
);
    logic         rx_done;
    logic [W-1:0] rx_word;
    logic         rx_noise;
    logic         rx_ferr;
    logic         rx_idle;

    uart_xcvr_tx #(.OSR(OSR), .W(W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .word9   (word9),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tx_out  (tx_out),
        .txe     (txe),
        .tc      (tc)
    );

    uart_xcvr_rx #(.OSR(OSR), .W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .word9    (word9),
        .rx_in    (rx_in),
        .done     (rx_done),
        .word     (rx_word),
        .noise    (rx_noise),
        .ferr     (rx_ferr),
        .idle_evt (rx_idle)
    );

    uart_xcvr_rxflags #(.W(W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (rx_done),
        .word     (rx_word),
        .noise    (rx_noise),
        .ferr     (rx_ferr),
        .idle_evt (rx_idle),
        .rd_en    (rd_en),
        .rx_data  (rd_data),
        .rxne     (rxne),
        .ore      (ore),
        .ne       (ne),
        .fe       (fe),
        .idle     (idle)
    );

endmodule

// File: tb/sim_uart_xcvr.sv
`timescale 1ns/1ps
module sim_uart_xcvr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       word9 = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [8:0] rd_data;
    logic       rx_in = 1'b1;
    logic       tx_out, txe, tc, rxne, idle, ore, ne, fe;

    int nchk = 0;
    int errs = 0;
    int frames_seen = 0;
    bit finished = 1'b0;
    logic [8:0] txq[$];

    uart_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .word9(word9),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .rx_in(rx_in), .tx_out(tx_out), .txe(txe), .tc(tc), .rxne(rxne),
        .idle(idle), .ore(ore), .ne(ne), .fe(fe)
    );

    always #2 clk = ~clk;

    // Tick generator: one cycle high out of every four, changed at negedge.
    initial begin
        forever begin
            @(negedge clk) tick16 = 1'b1;
            @(negedge clk) tick16 = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Wait for n ticks consumed by the design, return at the following negedge.
    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
        @(negedge clk);
    endtask

    // One receive bit of 16 ticks, optionally flipping only the middle sample.
    task automatic rx_bit(input logic v, input bit glitch);
        rx_in = v;
        if (glitch) begin
            wait_ticks(8);
            rx_in = ~v;
            wait_ticks(1);
            rx_in = v;
            wait_ticks(7);
        end else begin
            wait_ticks(16);
        end
    endtask

    // Drive one frame onto rx_in; gbit 0 = start bit, i+1 = data bit i, -1 none.
    task automatic send_rx(input logic [8:0] d, input bit nine, input logic stopv, input int gbit);
        int n;
        n = nine ? 9 : 8;
        wait_ticks(1);
        rx_bit(1'b0, gbit == 0);
        for (int i = 0; i < n; i++) rx_bit(d[i], gbit == i + 1);
        rx_bit(stopv, 1'b0);
        rx_in = 1'b1;
    endtask

    task automatic rd();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    // Driver: write a word and, when the bench expects it accepted, queue it.
    task automatic wr(input logic [8:0] d, input bit expect_sent);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        if (expect_sent) txq.push_back(word9 ? d : {1'b0, d[7:0]});
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, nchk);
        end
    endtask

    // Monitor: decode each frame seen on tx_out and compare with the queue.
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (tx_out === 1'b0) begin
                logic [8:0] got;
                logic [8:0] exp;
                int n;
                n = word9 ? 9 : 8;
                got = '0;
                wait_ticks(8);
                chk("R2 start bit low", tx_out, 0);
                for (int i = 0; i < n; i++) begin
                    wait_ticks(16);
                    got[i] = tx_out;
                end
                wait_ticks(16);
                chk("R2 stop bit high", tx_out, 1);
                if (txq.size() == 0) begin
                    nchk++;
                    errs++;
                    $display("FAIL R3 unexpected frame: actual=%0h expected=none", got);
                end else begin
                    exp = txq.pop_front();
                    chk("R1 transmitted word", got, exp);
                end
                frames_seen++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 tx_out", tx_out, 1);
        chk("R12 txe", txe, 1);
        chk("R12 tc", tc, 1);
        chk("R12 rxne", rxne, 0);
        chk("R12 flags ore/ne/fe/idle", {ore, ne, fe, idle}, 0);

        // R11 no idle before any frame
        wait_ticks(200);
        chk("R11 idle before first frame", idle, 0);

        // R5 / R1 8-bit receive
        word9 = 1'b0;
        send_rx(9'h0A5, 1'b0, 1'b1, -1);
        chk("R5 rxne after frame", rxne, 1);
        chk("R1 8-bit rx word", rd_data, 9'h0A5);
        chk("R8 no noise on clean frame", ne, 0);
        chk("R9 no framing error", fe, 0);
        wait_ticks(100);
        chk("R11 idle not yet", idle, 0);
        wait_ticks(120);
        chk("R11 idle after frame time", idle, 1);
        rd();
        chk("R6 rxne cleared by read", rxne, 0);
        chk("R6 idle cleared by read", idle, 0);
        wait_ticks(250);
        chk("R11 idle not repeated", idle, 0);

        // R1 9-bit receive
        word9 = 1'b1;
        send_rx(9'h1C3, 1'b1, 1'b1, -1);
        chk("R1 9-bit rx word", rd_data, 9'h1C3);
        rd();

        // R7 overrun
        word9 = 1'b0;
        send_rx(9'h011, 1'b0, 1'b1, -1);
        send_rx(9'h022, 1'b0, 1'b1, -1);
        chk("R7 ore set", ore, 1);
        chk("R7 old word kept", rd_data, 9'h011);
        rd();
        chk("R6 ore cleared", {ore, rxne}, 0);

        // R8 noise on data bit 2
        send_rx(9'h03C, 1'b0, 1'b1, 3);
        chk("R8 majority data", rd_data, 9'h03C);
        chk("R8 ne set", ne, 1);
        rd();
        chk("R6 ne cleared", ne, 0);

        // R9 framing error
        send_rx(9'h05A, 1'b0, 1'b0, -1);
        chk("R9 word delivered", rd_data, 9'h05A);
        chk("R9 fe set", fe, 1);
        rd();
        wait_ticks(40);
        chk("R10 no word after low stop", rxne, 0);

        // R10 false start then a valid frame
        rx_in = 1'b0;
        wait_ticks(6);
        rx_in = 1'b1;
        wait_ticks(40);
        chk("R10 short pulse rejected", rxne, 0);
        send_rx(9'h077, 1'b0, 1'b1, -1);
        chk("R10 next frame received", rd_data, 9'h077);
        rd();

        // R3 / R4 transmit, 8-bit, back to back
        word9 = 1'b0;
        wr(9'h196, 1'b1);
        @(negedge clk);
        chk("R3 txe after move to shifter", txe, 1);
        chk("R4 tc cleared by write", tc, 0);
        wr(9'h00F, 1'b1);
        chk("R3 txe low while held", txe, 0);
        wr(9'h1FF, 1'b0);
        wait_ticks(200);
        chk("R4 tc low during back-to-back", tc, 0);
        wait_ticks(160);
        chk("R4 tc after last stop", tc, 1);
        chk("R3 frames sent", frames_seen, 2);

        // R1 transmit, 9-bit
        word9 = 1'b1;
        wr(9'h155, 1'b1);
        wait_ticks(200);
        chk("R4 tc after 9-bit frame", tc, 1);
        chk("R1 all frames seen", frames_seen, 3);
        chk("R1 queue drained", txq.size(), 0);

        summary();
        $finish;
    end
endmodule